// File: doc/BRIEF.md
# LIN Break Field Detector

The block times the low phase of a LIN bus line to recognise the break that opens every frame. The received line is resynchronised, and its falling and rising edges are found in the core clock domain. A 12-bit counter then advances once per pulse of a slow tick enable, which stands in for a low-power oscillator of about 131 kHz, for as long as the line stays low. Software sets a threshold in a compare register. When the running count reaches that threshold during a low pulse, the block raises a break flag and a one-cycle interrupt.

If the line stays low long enough to exhaust the counter, the block treats it as a stuck bus. It raises a separate error flag and interrupt, and the counter stops at its top value. Reading the count through the register port returns its value and clears it. Writing through the same port loads only the compare threshold. A qualifier output tells a downstream sync-field timer that a valid break has just ended, so that it may start measuring the sync byte.

Top module: `lin_brk_det`

## Requirements
- R1: After synchronous reset the compare register holds 0x047, the count reads 0, and `brk_flag`, `err_flag`, both interrupts and `sync_ok` are 0.
- R2: `bus_in` passes through a two-flop synchronizer. A falling edge of the synchronized line sets the counter to 0 and starts a new low pulse.
- R3: While `enable` is 1 and the synchronized line is low, the counter adds one on each cycle with `tick_en` high. With `tick_en` low it holds. With a tick on every cycle, a low pulse of L clock cycles leaves a count of L-1.
- R4: A cycle with `rd_en` high places the current count on `rd_data` one cycle later and sets the counter to 0.
- R5: A cycle with `wr_en` high loads `wr_data` into the compare register, which is visible on `cmp_val`. The counter is not changed.
- R6: During a low pulse, when the count equals the compare value, `brk_flag` is set and `brk_irq` is high for exactly one cycle. This happens at most once per low pulse, even if the count is cleared and passes the value again. With a tick on every cycle, this means a break is flagged when the measured count is at least the compare value.
- R7: The counter stops at 4095 and does not wrap. The tick that would take it past 4095 (the 4096th tick of a pulse) sets `err_flag` and pulses `err_irq` for one cycle.
- R8: The flags stay set until a cycle with `clr_brk` (for `brk_flag`) or `clr_err` (for `err_flag`) high clears them. A new set event in the same cycle wins. Each clear affects only its own flag.
- R9: `sync_ok` rises on the rising edge that ends a low pulse in which a break was flagged and no overflow occurred. It falls on an overflow error, on `clr_brk`, or while `enable` is 0.
- R10: While `enable` is 0 the counter does not advance and no break is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Asynchronous LIN receive line, idle high |
| tick_en | input | 1 | Slow-oscillator tick enable, one cycle per tick |
| enable | input | 1 | Enables counting and compare |
| rd_en | input | 1 | Read strobe for the count, clears the counter |
| rd_data | output | 12 | Count captured by the last read |
| wr_en | input | 1 | Write strobe for the compare register |
| wr_data | input | 12 | New compare value |
| cmp_val | output | 12 | Current compare value |
| clr_brk | input | 1 | Write-1-to-clear for the break flag |
| clr_err | input | 1 | Write-1-to-clear for the error flag |
| brk_flag | output | 1 | Sticky break-detected status |
| err_flag | output | 1 | Sticky break-field error status |
| brk_irq | output | 1 | One-cycle break interrupt |
| err_irq | output | 1 | One-cycle break-field error interrupt |
| sync_ok | output | 1 | Valid-break qualifier for the sync-field timer |

## Verification
The assertions take for granted that the counter clears only on a synchronized falling edge or a read strobe. They also assume that `rd_en` and the clear strobes are single-cycle register accesses that are not held high across a whole pulse. The stimulus keeps to this: every strobe is driven for one cycle at the falling clock edge. Each low pulse is preceded and followed by several idle-high cycles, so every pulse gives the synchronizer a clean pair of edges. The bus line is driven at the falling clock edge, so edge timing at the synchronizer is exact and expected counts follow from the pulse length.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  typedef struct packed {
    logic low;
    logic fall;
    logic rise;
  } lin_edge_t;

  localparam int unsigned DEF_CNT_W = 12;
endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync
  import lin_brk_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bus_in,
  output lin_edge_t ev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= bus_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], bus_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  always_comb begin
    ev.low  = ~chain_q[STAGES-1];
    ev.fall = prev_q & ~chain_q[STAGES-1];
    ev.rise = ~prev_q & chain_q[STAGES-1];
  end
endmodule

// File: rtl/lin_brk_cnt.sv
module lin_brk_cnt
  import lin_brk_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  lin_edge_t        ev,
  input  logic             tick_en,
  input  logic             enable,
  input  logic             rd_en,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             ovf_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic advance;
  logic clear;

  assign clear   = ev.fall | rd_en;
  assign advance = enable & tick_en & ev.low & ~ovf & ~clear;
  assign ovf_hit = advance & (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (advance && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (ev.fall) ovf <= 1'b0;
    else if (ovf_hit) ovf <= 1'b1;
  end
endmodule

// File: rtl/lin_brk_flags.sv
module lin_brk_flags
  import lin_brk_pkg::*;
#(
  parameter int unsigned    CNT_W   = DEF_CNT_W,
  parameter logic [CNT_W-1:0] CMP_RST = 12'h047
) (
  input  logic             clk,
  input  logic             rst,
  input  lin_edge_t        ev,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovf,
  input  logic             ovf_hit,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_brk,
  input  logic             clr_err,
  output logic [CNT_W-1:0] cmp_val,
  output logic             brk_flag,
  output logic             err_flag,
  output logic             brk_irq,
  output logic             err_irq,
  output logic             sync_ok
);
  logic armed_q;
  logic seen_q;
  logic fire;

  assign fire = armed_q & enable & (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)        cmp_val <= CMP_RST;
    else if (wr_en) cmp_val <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                  armed_q <= 1'b0;
    else if (ev.fall)         armed_q <= 1'b1;
    else if (fire || ev.rise) armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                     seen_q <= 1'b0;
    else if (fire)               seen_q <= 1'b1;
    else if (ev.fall || clr_brk) seen_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_flag <= 1'b0;
      err_flag <= 1'b0;
      brk_irq  <= 1'b0;
      err_irq  <= 1'b0;
    end else begin
      brk_irq <= fire;
      err_irq <= ovf_hit;
      if (fire)         brk_flag <= 1'b1;
      else if (clr_brk) brk_flag <= 1'b0;
      if (ovf_hit)      err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                       sync_ok <= 1'b0;
    else if (ovf_hit || clr_brk || !enable)        sync_ok <= 1'b0;
    else if (ev.rise && (seen_q || fire) && !ovf)  sync_ok <= 1'b1;
  end
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
  import lin_brk_pkg::*;
#(
  parameter int unsigned      CNT_W       = DEF_CNT_W,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CMP_RST     = 12'h047
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_in,
  input  logic             tick_en,
  input  logic             enable,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_val,
  input  logic             clr_brk,
  input  logic             clr_err,
  output logic             brk_flag,
  output logic             err_flag,
  output logic             brk_irq,
  output logic             err_irq,
  output logic             sync_ok
);
  lin_edge_t        ev_w;
  logic [CNT_W-1:0] cnt_w;
  logic             ovf_w;
  logic             ovf_hit_w;

  lin_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .bus_in (bus_in),
    .ev     (ev_w)
  );

  lin_brk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev_w),
    .tick_en (tick_en),
    .enable  (enable),
    .rd_en   (rd_en),
    .cnt     (cnt_w),
    .ovf     (ovf_w),
    .ovf_hit (ovf_hit_w)
  );

  lin_brk_flags #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_w),
    .enable   (enable),
    .cnt      (cnt_w),
    .ovf      (ovf_w),
    .ovf_hit  (ovf_hit_w),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .clr_brk  (clr_brk),
    .clr_err  (clr_err),
    .cmp_val  (cmp_val),
    .brk_flag (brk_flag),
    .err_flag (err_flag),
    .brk_irq  (brk_irq),
    .err_irq  (err_irq),
    .sync_ok  (sync_ok)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= cnt_w;
  end
endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk
  import lin_brk_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input lin_edge_t        ev,
  input logic [CNT_W-1:0] cnt,
  input logic             brk_irq,
  input logic             brk_flag,
  input logic             err_irq,
  input logic             err_flag,
  input logic             sync_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R6: interrupt always accompanied by its sticky status
  p_brk_flag_r6: assert property (@(posedge clk) disable iff (rst)
    brk_irq |-> brk_flag);

  // R6: never two break interrupts back to back
  p_single_irq_r6: assert property (@(posedge clk) disable iff (rst)
    brk_irq |=> !brk_irq);

  // R7: error interrupt accompanied by error status
  p_err_flag_r7: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> err_flag);

  // R7: counter saturates, no wrap
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !ev.fall && !rd_en) |=> cnt == CNT_MAX);

  // R2: falling edge clears counter
  p_fall_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ev.fall |=> cnt == '0);

  // R4: read clears counter
  p_read_clear_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> cnt == '0);

  // R9: overflow error withdraws the sync qualifier
  p_err_kills_sync_r9: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> !sync_ok);
endmodule

bind lin_brk_det lin_brk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .ev       (ev_w),
  .cnt      (cnt_w),
  .brk_irq  (brk_irq),
  .brk_flag (brk_flag),
  .err_irq  (err_irq),
  .err_flag (err_flag),
  .sync_ok  (sync_ok)
);

// File: tb/lin_brk_det_tb.sv
module lin_brk_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst, bus_in, tick_en, enable, rd_en, wr_en, clr_brk, clr_err;
  logic [W-1:0] wr_data, rd_data, cmp_val;
  logic brk_flag, err_flag, brk_irq, err_irq, sync_ok;

  int errors = 0;
  int checks = 0;
  int brk_pulses = 0;
  int err_pulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_brk_det dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .tick_en(tick_en), .enable(enable),
    .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
    .cmp_val(cmp_val), .clr_brk(clr_brk), .clr_err(clr_err),
    .brk_flag(brk_flag), .err_flag(err_flag), .brk_irq(brk_irq),
    .err_irq(err_irq), .sync_ok(sync_ok)
  );

  always @(negedge clk) begin
    if (brk_irq) brk_pulses++;
    if (err_irq) err_pulses++;
  end

  typedef struct packed {
    logic [11:0] cmp;
    logic [15:0] len;
    logic [11:0] cnt;
    logic        brk;
    logic        err;
    logic        syn;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{cmp:12'h047, len:16'd100,  cnt:12'd99,   brk:1'b1, err:1'b0, syn:1'b1},
    '{cmp:12'h047, len:16'd72,   cnt:12'd71,   brk:1'b1, err:1'b0, syn:1'b1},
    '{cmp:12'h047, len:16'd71,   cnt:12'd70,   brk:1'b0, err:1'b0, syn:1'b0},
    '{cmp:12'd10,  len:16'd5,    cnt:12'd4,    brk:1'b0, err:1'b0, syn:1'b0},
    '{cmp:12'd4,   len:16'd5,    cnt:12'd4,    brk:1'b1, err:1'b0, syn:1'b1},
    '{cmp:12'd200, len:16'd4096, cnt:12'd4095, brk:1'b1, err:1'b0, syn:1'b1},
    '{cmp:12'hFFF, len:16'd4097, cnt:12'd4095, brk:1'b1, err:1'b1, syn:1'b0},
    '{cmp:12'd200, len:16'd4097, cnt:12'd4095, brk:1'b1, err:1'b1, syn:1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [W-1:0] v);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_write(input logic [W-1:0] v);
    @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic do_clear(input bit b, input bit e);
    @(negedge clk) begin clr_brk = b; clr_err = e; end
    @(negedge clk) begin clr_brk = 1'b0; clr_err = 1'b0; end
  endtask

  task automatic pulse(input int len);
    @(negedge clk) bus_in = 1'b0;
    repeat (len) @(negedge clk);
    bus_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, mid;
    rst = 1'b1; bus_in = 1'b1; tick_en = 1'b1; enable = 1'b1;
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; clr_brk = 1'b0; clr_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(cmp_val == 12'h047, "R1 cmp reset", cmp_val, 12'h047);
    chk({brk_flag, err_flag, brk_irq, err_irq, sync_ok} == 5'b0, "R1 outputs idle",
        {brk_flag, err_flag, brk_irq, err_irq, sync_ok}, 0);
    do_read(v);
    chk(v == 0, "R1 count reset", v, 0);

    // R3 R6 R7 R9 table of pulses, tick every cycle
    for (int i = 0; i < NV; i++) begin
      do_clear(1'b1, 1'b1);
      do_write(VECS[i].cmp);
      brk_pulses = 0; err_pulses = 0;
      pulse(int'(VECS[i].len));
      chk(brk_flag == VECS[i].brk, "R6 break flag", brk_flag, VECS[i].brk);
      chk(brk_pulses == int'(VECS[i].brk), "R6 break irq count", brk_pulses, VECS[i].brk);
      chk(err_flag == VECS[i].err, "R7 error flag", err_flag, VECS[i].err);
      chk(err_pulses == int'(VECS[i].err), "R7 error irq count", err_pulses, VECS[i].err);
      chk(sync_ok == VECS[i].syn, "R9 sync qualifier", sync_ok, VECS[i].syn);
      do_read(v);
      chk(v == VECS[i].cnt, "R3 measured count", v, VECS[i].cnt);
    end

    // R8 clears are independent (both flags set by last vector)
    do_clear(1'b0, 1'b1);
    chk(err_flag == 1'b0, "R8 err cleared", err_flag, 0);
    chk(brk_flag == 1'b1, "R8 brk kept", brk_flag, 1);
    do_clear(1'b1, 1'b0);
    chk(brk_flag == 1'b0, "R8 brk cleared", brk_flag, 0);

    // R4 read clears; second read returns 0
    do_write(12'd5);
    pulse(30);
    // R5 write after pulse does not touch counter
    do_write(12'h0AB);
    chk(cmp_val == 12'h0AB, "R5 compare readback", cmp_val, 12'h0AB);
    do_read(v);
    chk(v == 12'd29, "R5 count untouched by write", v, 29);
    do_read(v);
    chk(v == 12'd0, "R4 read clears count", v, 0);

    // R6 once per pulse with mid-pulse read; R4 mid-pulse value
    do_clear(1'b1, 1'b1);
    do_write(12'd3);
    brk_pulses = 0;
    @(negedge clk) bus_in = 1'b0;
    repeat (20) @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    mid = rd_data;
    repeat (19) @(negedge clk);
    bus_in = 1'b1;
    repeat (6) @(negedge clk);
    chk(mid == 12'd17, "R4 mid-pulse read", mid, 17);
    chk(brk_pulses == 1, "R6 single irq per pulse", brk_pulses, 1);
    do_read(v);
    chk(v == 12'd21, "R4 count restarts after read", v, 21);

    // R2 a new falling edge restarts from zero
    pulse(10);
    do_read(v);
    chk(v == 12'd9, "R2 fall restarts count", v, 9);

    // R3 no tick, no count
    do_clear(1'b1, 1'b1);
    do_write(12'd5);
    tick_en = 1'b0;
    pulse(30);
    do_read(v);
    chk(v == 12'd0, "R3 tick gated count", v, 0);
    chk(brk_flag == 1'b0, "R3 tick gated no break", brk_flag, 0);
    tick_en = 1'b1;

    // R9 enable low drops sync_ok
    pulse(20);
    chk(sync_ok == 1'b1, "R9 sync set", sync_ok, 1);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(sync_ok == 1'b0, "R9 sync dropped by enable", sync_ok, 0);

    // R10 disabled: no count, no break
    do_read(v);
    do_clear(1'b1, 1'b1);
    pulse(30);
    do_read(v);
    chk(v == 12'd0, "R10 disabled count", v, 0);
    chk(brk_flag == 1'b0, "R10 disabled no break", brk_flag, 0);
    enable = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule